// File: doc/BRIEF.md
# Radio Power Mode Sequencer

This block tracks the operating mode of a low-power radio transceiver and gates the reference oscillator and the receive and transmit front ends to match. It has eight states: Off, Hibernate, Doze, Idle, the two warm-up states ahead of Receive and Transmit, and Receive and Transmit themselves. Host software moves it into the sleep states through single-cycle command strobes that are decoded from the register file. Wake comes from an active-low attention line and, in Doze only, from a wake timer compare. A separate enable line runs the radio sequences: a rising edge starts a sequence and a low level aborts it or ends it.

The time from Idle to an active radio mode is a settling delay. It is counted in reference clock cycles and can be set separately for receive and for transmit. A level-held ready interrupt tells the host that Idle has been reached after reset or after a wake. A configuration bit can route an "out of idle" flag to a general-purpose pin.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rstN` is low, `mode` reads 0 (Off) and `oscEn`, `rfRxEn`, `rfTxEn`, `outOfIdle` and `readyIrq` are all 0, without waiting for a clock edge. The first clock edge after release moves `mode` to 3 (Idle).
- R2: In Idle, `cmdHib` moves `mode` to 1 (Hibernate) and `cmdDoze` moves it to 2 (Doze). If both are high, Hibernate wins. Both commands are ignored in every other mode.
- R3: A low `attnN` in Hibernate or Doze returns `mode` to Idle at the next edge. A low `attnN` in Idle has no effect.
- R4: In Doze, `timerMatch` with `timerWakeEn` high returns `mode` to Idle. `timerMatch` is ignored when `timerWakeEn` is low, and it is always ignored in Hibernate.
- R5: A rising edge on `rxTxEn` seen in Idle moves `mode` to 4 (receive warm-up) when `txSel` is 0 and to 6 (transmit warm-up) when `txSel` is 1. An edge outside Idle does not start a sequence, and neither does a level held high (including one held through reset).
- R6: `mode` stays in 4 for exactly `RX_WARM_CYC` cycles and then reads 5 (Receive). It stays in 6 for exactly `TX_WARM_CYC` cycles and then reads 7 (Transmit).
- R7: A low `rxTxEn` in any of modes 4 to 7 returns `mode` to Idle at the next edge. Sleep commands are ignored while a sequence runs.
- R8: `oscEn` is 0 in Off and Hibernate and 1 in every other mode. `rfRxEn` is 1 only in modes 4 and 5, and `rfTxEn` is 1 only in modes 6 and 7.
- R9: `outOfIdle` is 1 exactly when `altIdleEn` is 1 and `mode` is 4, 5, 6 or 7.
- R10: `readyIrq` goes to 1 on entry to Idle from Off, Hibernate or Doze. It stays at 1 until a cycle with `irqRead` high clears it. If a set and a read fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset; holds Off |
| attnN | input | 1 | Active-low attention wake line |
| rxTxEn | input | 1 | Sequence enable; rising edge starts, low level ends |
| txSel | input | 1 | Register bit: 1 selects transmit, 0 receive |
| cmdHib | input | 1 | Register command strobe: enter Hibernate |
| cmdDoze | input | 1 | Register command strobe: enter Doze |
| timerWakeEn | input | 1 | Register bit: allow timer wake from Doze |
| timerMatch | input | 1 | Wake timer compare event |
| irqRead | input | 1 | Register read strobe that clears the ready interrupt |
| altIdleEn | input | 1 | Register bit: route out-of-idle flag to pin |
| mode | output | 3 | Current mode code |
| oscEn | output | 1 | Reference oscillator enable |
| rfRxEn | output | 1 | Receiver enable |
| rfTxEn | output | 1 | Transmitter enable |
| outOfIdle | output | 1 | Out-of-idle indicator pin |
| readyIrq | output | 1 | Level-held ready interrupt |

## Verification
The properties assume that all inputs are synchronous to `clk`. They also assume that the command and timer strobes carry meaning only in the modes listed above, and that the warm-up parameters are at least 1. The stimulus changes inputs only on the falling clock edge and returns `rxTxEn` low before it starts a new sequence. It holds `attnN` low for one cycle at a time, except in the deliberate checks that low attention has no effect in Idle. The bench builds the block with short warm-up counts so that the exact cycle boundaries of R6 can be observed.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    MODE_OFF     = 3'd0,
    MODE_HIB     = 3'd1,
    MODE_DOZE    = 3'd2,
    MODE_IDLE    = 3'd3,
    MODE_RX_WARM = 3'd4,
    MODE_RX      = 3'd5,
    MODE_TX_WARM = 3'd6,
    MODE_TX      = 3'd7
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWarm;
    logic warmIsTx;
    logic setIrq;
  } seq_strobe_t;

endpackage

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int RX_WARM_CYC = 2304,
  parameter int TX_WARM_CYC = 2304
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxTxEn,
  input  logic        irqRead,
  input  seq_strobe_t strobe,
  output logic        enRise,
  output logic        warmDone,
  output logic        readyIrq
);

  localparam int MAX_CYC = (RX_WARM_CYC > TX_WARM_CYC) ? RX_WARM_CYC : TX_WARM_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RX_LOAD = CNT_W'(RX_WARM_CYC - 1);
  localparam logic [CNT_W-1:0] TX_LOAD = CNT_W'(TX_WARM_CYC - 1);

  logic             enPrev;
  logic [CNT_W-1:0] warmCnt;
  logic             irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= rxTxEn;
  end

  assign enRise = rxTxEn & ~enPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                warmCnt <= '0;
    else if (strobe.loadWarm) warmCnt <= strobe.warmIsTx ? TX_LOAD : RX_LOAD;
    else if (warmCnt != '0)   warmCnt <= warmCnt - 1'b1;
  end

  assign warmDone = (warmCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              irqQ <= 1'b0;
    else if (strobe.setIrq) irqQ <= 1'b1;
    else if (irqRead)       irqQ <= 1'b0;
  end

  assign readyIrq = irqQ;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        attnN,
  input  logic        rxTxEn,
  input  logic        enRise,
  input  logic        txSel,
  input  logic        cmdHib,
  input  logic        cmdDoze,
  input  logic        timerWakeEn,
  input  logic        timerMatch,
  input  logic        warmDone,
  output mode_e       mode,
  output seq_strobe_t strobe
);

  mode_e nextMode;

  always_comb begin
    nextMode = mode;
    strobe   = '0;
    unique case (mode)
      MODE_OFF: begin
        nextMode      = MODE_IDLE;
        strobe.setIrq = 1'b1;
      end
      MODE_HIB: begin
        if (!attnN) begin
          nextMode      = MODE_IDLE;
          strobe.setIrq = 1'b1;
        end
      end
      MODE_DOZE: begin
        if (!attnN || (timerWakeEn && timerMatch)) begin
          nextMode      = MODE_IDLE;
          strobe.setIrq = 1'b1;
        end
      end
      MODE_IDLE: begin
        if (enRise) begin
          strobe.loadWarm = 1'b1;
          strobe.warmIsTx = txSel;
          nextMode        = txSel ? MODE_TX_WARM : MODE_RX_WARM;
        end else if (cmdHib) begin
          nextMode = MODE_HIB;
        end else if (cmdDoze) begin
          nextMode = MODE_DOZE;
        end
      end
      MODE_RX_WARM: begin
        if (!rxTxEn)       nextMode = MODE_IDLE;
        else if (warmDone) nextMode = MODE_RX;
      end
      MODE_TX_WARM: begin
        if (!rxTxEn)       nextMode = MODE_IDLE;
        else if (warmDone) nextMode = MODE_TX;
      end
      MODE_RX, MODE_TX: begin
        if (!rxTxEn) nextMode = MODE_IDLE;
      end
      default: nextMode = MODE_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_OFF;
    else       mode <= nextMode;
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int RX_WARM_CYC = 2304,
  parameter int TX_WARM_CYC = 2304
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       attnN,
  input  logic       rxTxEn,
  input  logic       txSel,
  input  logic       cmdHib,
  input  logic       cmdDoze,
  input  logic       timerWakeEn,
  input  logic       timerMatch,
  input  logic       irqRead,
  input  logic       altIdleEn,
  output logic [2:0] mode,
  output logic       oscEn,
  output logic       rfRxEn,
  output logic       rfTxEn,
  output logic       outOfIdle,
  output logic       readyIrq
);

  mode_e       curMode;
  seq_strobe_t strobe;
  logic        enRise;
  logic        warmDone;

  pwr_mode_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .attnN      (attnN),
    .rxTxEn     (rxTxEn),
    .enRise     (enRise),
    .txSel      (txSel),
    .cmdHib     (cmdHib),
    .cmdDoze    (cmdDoze),
    .timerWakeEn(timerWakeEn),
    .timerMatch (timerMatch),
    .warmDone   (warmDone),
    .mode       (curMode),
    .strobe     (strobe)
  );

  pwr_mode_dp #(
    .RX_WARM_CYC(RX_WARM_CYC),
    .TX_WARM_CYC(TX_WARM_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .rxTxEn  (rxTxEn),
    .irqRead (irqRead),
    .strobe  (strobe),
    .enRise  (enRise),
    .warmDone(warmDone),
    .readyIrq(readyIrq)
  );

  assign mode      = curMode;
  assign oscEn     = (curMode != MODE_OFF) && (curMode != MODE_HIB);
  assign rfRxEn    = (curMode == MODE_RX_WARM) || (curMode == MODE_RX);
  assign rfTxEn    = (curMode == MODE_TX_WARM) || (curMode == MODE_TX);
  assign outOfIdle = altIdleEn && curMode[2];

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk
  import pwr_mode_pkg::*;
#(
  parameter int RX_WARM_CYC = 2304,
  parameter int TX_WARM_CYC = 2304
) (
  input logic       clk,
  input logic       rstN,
  input logic       attnN,
  input logic       rxTxEn,
  input logic       irqRead,
  input logic [2:0] mode,
  input logic       readyIrq
);

  logic [31:0] rxCnt;
  logic [31:0] txCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCnt <= '0;
      txCnt <= '0;
    end else begin
      rxCnt <= (mode == MODE_RX_WARM) ? rxCnt + 1 : '0;
      txCnt <= (mode == MODE_TX_WARM) ? txCnt + 1 : '0;
    end
  end

  a_r1_off_in_reset: assert property (@(negedge clk) !rstN |-> mode == MODE_OFF);

  a_r2_sleep_only_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_IDLE && mode != MODE_HIB) |=> mode != MODE_HIB);

  a_r3_attn_wakes_hib: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_HIB && !attnN) |=> mode == MODE_IDLE);

  a_r6_rx_warm_len: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RX && $past(mode) == MODE_RX_WARM) |-> rxCnt == 32'(RX_WARM_CYC));

  a_r6_tx_warm_len: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_TX && $past(mode) == MODE_TX_WARM) |-> txCnt == 32'(TX_WARM_CYC));

  a_r7_en_low_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (mode[2] && !rxTxEn) |=> mode == MODE_IDLE);

  a_r10_irq_held: assert property (@(posedge clk) disable iff (!rstN)
    (readyIrq && !irqRead) |=> readyIrq);

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(
  .RX_WARM_CYC(RX_WARM_CYC),
  .TX_WARM_CYC(TX_WARM_CYC)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .attnN   (attnN),
  .rxTxEn  (rxTxEn),
  .irqRead (irqRead),
  .mode    (mode),
  .readyIrq(readyIrq)
);

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;

  localparam int RXW = 6;
  localparam int TXW = 4;
  localparam int NVEC = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic attnN = 1'b1, rxTxEn = 1'b0, txSel = 1'b0, cmdHib = 1'b0, cmdDoze = 1'b0;
  logic timerWakeEn = 1'b0, timerMatch = 1'b0, irqRead = 1'b0, altIdleEn = 1'b0;
  logic [2:0] mode;
  logic oscEn, rfRxEn, rfTxEn, outOfIdle, readyIrq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pwr_mode_seq #(.RX_WARM_CYC(RXW), .TX_WARM_CYC(TXW)) u_dut (
    .clk(clk), .rstN(rstN), .attnN(attnN), .rxTxEn(rxTxEn), .txSel(txSel),
    .cmdHib(cmdHib), .cmdDoze(cmdDoze), .timerWakeEn(timerWakeEn),
    .timerMatch(timerMatch), .irqRead(irqRead), .altIdleEn(altIdleEn),
    .mode(mode), .oscEn(oscEn), .rfRxEn(rfRxEn), .rfTxEn(rfTxEn),
    .outOfIdle(outOfIdle), .readyIrq(readyIrq)
  );

  // {attnN, rxTxEn, txSel, cmdHib, cmdDoze, timerWakeEn, timerMatch, irqRead, expMode[2:0], expIrq}
  localparam logic [11:0] VEC [NVEC] = '{
    12'b1_0_0_0_0_0_0_1_011_0,
    12'b1_0_0_0_1_0_0_0_010_0,
    12'b1_0_0_0_0_0_1_0_010_0,
    12'b1_0_0_1_0_0_0_0_010_0,
    12'b1_0_0_0_0_1_1_0_011_1,
    12'b1_0_0_0_0_0_0_1_011_0,
    12'b1_0_0_1_0_0_0_0_001_0,
    12'b1_0_0_0_0_1_1_0_001_0,
    12'b1_1_0_0_0_0_0_0_001_0,
    12'b0_1_0_0_0_0_0_0_011_1,
    12'b1_1_0_0_0_0_0_0_011_1,
    12'b1_0_0_1_1_0_0_0_001_1,
    12'b0_0_0_0_0_0_0_0_011_1,
    12'b1_0_0_0_0_0_0_1_011_0,
    12'b0_0_0_0_0_0_0_0_011_0
  };

  string rowTag [NVEC] = '{
    "R10 read clears", "R2 doze cmd", "R4 match w/o enable", "R2 cmd ignored in doze",
    "R4 timer wake", "R10 read clears", "R2 hib cmd", "R4 no timer exit from hib",
    "R5 edge outside idle", "R3 attn wakes hib", "R5 held level", "R2 hib priority",
    "R3 attn wakes hib", "R10 read clears", "R3 attn no effect in idle"
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idleInputs();
    attnN = 1'b1; rxTxEn = 1'b0; txSel = 1'b0; cmdHib = 1'b0; cmdDoze = 1'b0;
    timerWakeEn = 1'b0; timerMatch = 1'b0; irqRead = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode in reset", mode, 0);
    chk("R1 oscEn in reset", oscEn, 0);
    chk("R1 irq in reset", readyIrq, 0);
    rstN = 1'b1;
    tick();
    chk("R1 idle after release", mode, 3);
    chk("R10 irq after reset", readyIrq, 1);

    for (int i = 0; i < NVEC; i++) begin
      {attnN, rxTxEn, txSel, cmdHib, cmdDoze, timerWakeEn, timerMatch, irqRead} = VEC[i][11:4];
      tick();
      chk($sformatf("%s row %0d mode", rowTag[i], i), mode, int'(VEC[i][3:1]));
      chk($sformatf("%s row %0d irq", rowTag[i], i), readyIrq, int'(VEC[i][0]));
    end
    idleInputs();
    tick();

    // receive sequence
    altIdleEn = 1'b1;
    rxTxEn = 1'b1; txSel = 1'b0;
    tick();
    chk("R5 rx warm entry", mode, 4);
    chk("R8 rfRxEn in warm", rfRxEn, 1);
    chk("R9 outOfIdle on", outOfIdle, 1);
    repeat (RXW - 1) tick();
    chk("R6 still rx warm", mode, 4);
    tick();
    chk("R6 rx active", mode, 5);
    cmdHib = 1'b1;
    tick();
    chk("R7 cmd ignored in rx", mode, 5);
    cmdHib = 1'b0; rxTxEn = 1'b0;
    tick();
    chk("R7 rx ends", mode, 3);
    chk("R9 outOfIdle off in idle", outOfIdle, 0);
    chk("R8 rfRxEn off", rfRxEn, 0);

    // transmit sequence
    altIdleEn = 1'b0;
    rxTxEn = 1'b1; txSel = 1'b1;
    tick();
    chk("R5 tx warm entry", mode, 6);
    chk("R8 rfTxEn in warm", rfTxEn, 1);
    chk("R9 outOfIdle masked", outOfIdle, 0);
    repeat (TXW - 1) tick();
    chk("R6 still tx warm", mode, 6);
    tick();
    chk("R6 tx active", mode, 7);
    rxTxEn = 1'b0;
    tick();
    chk("R7 tx ends", mode, 3);

    // abort warm-up, then a fresh edge
    rxTxEn = 1'b1; txSel = 1'b0;
    tick();
    chk("R5 warm again", mode, 4);
    rxTxEn = 1'b0;
    tick();
    chk("R7 abort warm", mode, 3);
    rxTxEn = 1'b1;
    tick();
    chk("R5 new edge restarts", mode, 4);
    rxTxEn = 1'b0;
    tick();

    // interrupt set beats read; oscillator per mode
    irqRead = 1'b1;
    tick();
    chk("R10 cleared", readyIrq, 0);
    irqRead = 1'b0; cmdDoze = 1'b1;
    tick();
    chk("R2 doze", mode, 2);
    chk("R8 osc on in doze", oscEn, 1);
    cmdDoze = 1'b0; attnN = 1'b0; irqRead = 1'b1;
    tick();
    chk("R3 doze attn wake", mode, 3);
    chk("R10 set wins over read", readyIrq, 1);
    attnN = 1'b1; irqRead = 1'b0; cmdHib = 1'b1;
    tick();
    chk("R8 osc off in hib", oscEn, 0);
    cmdHib = 1'b0; attnN = 1'b0;
    tick();
    attnN = 1'b1;
    chk("R3 hib wake", mode, 3);

    // reset during a sequence, enable held high through reset
    rxTxEn = 1'b1;
    tick();
    tick();
    rstN = 1'b0;
    #1;
    chk("R1 async off", mode, 0);
    chk("R1 rfRxEn off", rfRxEn, 0);
    chk("R1 irq off", readyIrq, 0);
    @(negedge clk);
    rstN = 1'b1;
    tick();
    chk("R1 idle after mid-run reset", mode, 3);
    chk("R10 irq after reset", readyIrq, 1);
    tick();
    chk("R5 held through reset no start", mode, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule